// File: doc/BRIEF.md
# Seconds Timer with Slow-Clock Counter and Backup Registers

This block keeps a free-running seconds count on a slow 32768 Hz clock while software reaches it over a simple single-cycle register bus on the fast system clock. A programmable prescaler divides the slow clock; every time it wraps, a 32-bit counter steps by one. The counter has no load path. Software can only zero it by setting a self-clearing clear bit in the mode register, which also restarts the prescaler. Wall time is kept by software as the counter plus an offset held in one of four general-purpose backup registers. The counter clear leaves these registers untouched.

An alarm register is compared with the counter each time the counter steps. A match latches a sticky status flag, and that flag drives the interrupt output. Mode and alarm settings reach the slow domain through a toggle handshake. The counter comes back to the fast domain through a plain multi-bit synchronizer, so a value read can be torn while the counter moves. Software treats two equal reads in a row as a valid sample. From the write that sets the clear bit until the clear has reached the slow domain and been acknowledged, the value register reads zero. Only one mode or alarm change may be in flight at a time.

Top module: `rt_seconds_timer`

## Requirements
- R1: After reset the mode register reads 0x0000_8000 (divider field bits [15:0] = 32768, clear bit 16 = 0), the alarm register reads 0xFFFF_FFFF, status reads 0, all backup registers read 0 and irq is 0.
- R2: bus_addr is a word index: 0 = mode, 1 = alarm, 2 = value, 3 = status, 4 to 7 = backup 0 to 3. Indices 8 to 15 read 0 and ignore writes. Read data appears on bus_rdata in the cycle after the read strobe.
- R3: With a divider field P of 2 or more, the counter steps by exactly one every P slow-clock cycles, and it changes only by stepping or by being cleared.
- R4: A divider field of 0 or of 1 makes the counter step on every slow-clock cycle.
- R5: A mode write with bit 16 set zeroes the counter and restarts the prescaler. Bit 16 always reads back 0, and the divider field reads back as written.
- R6: From the cycle after a mode write with bit 16 set until the clear has been acknowledged, reads of the value register return 0.
- R7: The value register cannot be written. A write to index 2 leaves the count unchanged.
- R8: When the counter steps to the alarm value, status bit 0 and irq go to 1 and stay there until status is read. That read returns 1 and clears both.
- R9: With the alarm at 0xFFFF_FFFF, irq stays 0 during normal counting.
- R10: Backup registers hold any written 32-bit value, and neither a counter clear nor a divider change alters them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock for the register bus |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| slow_clk | input | 1 | 32768 Hz counting clock |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Alarm interrupt, equal to the sticky alarm flag |

## Verification
The counter is run with divider values 4, 0, 1 and 2, and each run is read after a known span of slow cycles. This separates a true divide-by-P from an off-by-one, and shows whether 0 and 1 are taken as divide-by-one or as a near-stop or wrap value. Reads taken right after a clear, and after a write to the value index under a large divider, tell the read masking apart from a lingering old count or a count that software could load. An alarm at 50 is checked for silence before the match, for assertion at the match, and for the clear on reading status. An all-ones alarm shows that the flag stays silent when no match can occur. Backup patterns are read back after several clears to separate them from counter state.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  localparam int IX_MODE   = 0;
  localparam int IX_ALARM  = 1;
  localparam int IX_VALUE  = 2;
  localparam int IX_STATUS = 3;
  localparam int IX_BK0    = 4;

  // effective division ratio: 0 and 1 both mean "every slow cycle"
  function automatic int unsigned div_ratio(input int unsigned div);
    return (div < 2) ? 1 : div;
  endfunction

  // true when the prescaler count has reached the last cycle of a period
  function automatic logic div_done(input int unsigned cnt, input int unsigned div);
    return (cnt + 1) >= div_ratio(div);
  endfunction
endpackage

// File: rtl/rtt_toggle_sync.sv
module rtt_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic dst_clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], tgl_in};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign pulse_o = sh_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/rtt_bus_sync.sv
module rtt_bus_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         dst_clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= {st_q[STAGES-2:0], din};
  end

  assign dout = st_q[STAGES-1];
endmodule

// File: rtl/rtt_slow_core.sv
module rtt_slow_core
  import rtt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int DIV_W     = 16,
  parameter int PRESC_RST = 32768
) (
  input  logic             slow_clk,
  input  logic             rst_n,
  input  logic             cfg_evt,
  input  logic [DIV_W-1:0] presc_in,
  input  logic [CNT_W-1:0] alarm_in,
  input  logic             clr_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ack_tgl_o,
  output logic             alarm_tgl_o
);
  logic [DIV_W-1:0] presc_q, div_q;
  logic [CNT_W-1:0] cnt_q, alarm_q, cnt_nx;
  logic             ack_q, alrm_q;
  logic             clear_w, restart_w, tick_w, hit_w;

  assign clear_w   = cfg_evt && clr_in;
  assign restart_w = cfg_evt && (clr_in || (presc_in != presc_q));
  assign tick_w    = !restart_w && div_done(32'(div_q), 32'(presc_q));
  assign cnt_nx    = cnt_q + CNT_W'(1);
  assign hit_w     = tick_w && (cnt_nx == alarm_q);

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= DIV_W'(PRESC_RST);
      alarm_q <= '1;
      div_q   <= '0;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      alrm_q  <= 1'b0;
    end else begin
      if (cfg_evt) begin
        presc_q <= presc_in;
        alarm_q <= alarm_in;
        ack_q   <= ~ack_q;
      end
      if (restart_w || tick_w) div_q <= '0;
      else                     div_q <= div_q + DIV_W'(1);
      if (clear_w)     cnt_q <= '0;
      else if (tick_w) cnt_q <= cnt_nx;
      if (hit_w) alrm_q <= ~alrm_q;
    end
  end

  assign cnt_o       = cnt_q;
  assign ack_tgl_o   = ack_q;
  assign alarm_tgl_o = alrm_q;

  assert_cnt_step_R3: assert property (@(posedge slow_clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == '0)));

  assert_step_on_wrap_R3: assert property (@(posedge slow_clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (div_q == '0));

  assert_clear_R5: assert property (@(posedge slow_clk) disable iff (!rst_n)
    (cfg_evt && clr_in) |=> ((cnt_q == '0) && (div_q == '0)));

  assert_alarm_match_R8: assert property (@(posedge slow_clk) disable iff (!rst_n)
    (alrm_q != $past(alrm_q)) |-> (cnt_q == $past(alarm_q)));
endmodule

// File: rtl/rt_seconds_timer.sv
module rt_seconds_timer
  import rtt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NBK       = 4,
  parameter int CNT_W     = 32,
  parameter int DIV_W     = 16,
  parameter int PRESC_RST = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int CLR_BIT = DIV_W;
  localparam int IX_END  = IX_BK0 + NBK;

  logic [DIV_W-1:0] presc_r;
  logic [CNT_W-1:0] alarm_r;
  logic             clr_r, cfg_tgl, alarm_flag;
  logic [31:0]      bkup [NBK];
  logic [31:0]      rd_mux;
  logic [CNT_W-1:0] cnt_slow, cnt_fast;
  logic             ack_tgl_s, alarm_tgl_s, cfg_evt_s;
  logic             ack_evt, alarm_evt;
  logic             rd_any, wr_any, wr_mode, wr_alarm, rd_status, rd_value;

  assign rd_any    = bus_sel && !bus_wr;
  assign wr_any    = bus_sel && bus_wr;
  assign wr_mode   = wr_any && (int'(bus_addr) == IX_MODE);
  assign wr_alarm  = wr_any && (int'(bus_addr) == IX_ALARM);
  assign rd_status = rd_any && (int'(bus_addr) == IX_STATUS);
  assign rd_value  = rd_any && (int'(bus_addr) == IX_VALUE);

  // fast-domain control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_r    <= DIV_W'(PRESC_RST);
      alarm_r    <= '1;
      clr_r      <= 1'b0;
      cfg_tgl    <= 1'b0;
      alarm_flag <= 1'b0;
    end else begin
      if (wr_mode)  presc_r <= bus_wdata[DIV_W-1:0];
      if (wr_alarm) alarm_r <= bus_wdata[CNT_W-1:0];
      if (wr_mode || wr_alarm) cfg_tgl <= ~cfg_tgl;
      if (wr_mode && bus_wdata[CLR_BIT]) clr_r <= 1'b1;
      else if (ack_evt)                  clr_r <= 1'b0;
      if (alarm_evt)      alarm_flag <= 1'b1;
      else if (rd_status) alarm_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBK; i++) bkup[i] <= '0;
    end else begin
      for (int i = 0; i < NBK; i++)
        if (wr_any && (int'(bus_addr) == IX_BK0 + i)) bkup[i] <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (int'(bus_addr))
      IX_MODE:   rd_mux = 32'(presc_r);
      IX_ALARM:  rd_mux = 32'(alarm_r);
      IX_VALUE:  rd_mux = clr_r ? 32'd0 : 32'(cnt_fast);
      IX_STATUS: rd_mux = {31'd0, alarm_flag};
      default: begin
        for (int i = 0; i < NBK; i++)
          if (int'(bus_addr) == IX_BK0 + i) rd_mux = bkup[i];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_any) bus_rdata <= rd_mux;
  end

  assign irq = alarm_flag;

  // domain crossings
  rtt_toggle_sync #(.STAGES(2)) u_cfg_sync (
    .dst_clk(slow_clk), .rst_n(rst_n), .tgl_in(cfg_tgl), .pulse_o(cfg_evt_s));

  rtt_toggle_sync #(.STAGES(3)) u_ack_sync (
    .dst_clk(clk), .rst_n(rst_n), .tgl_in(ack_tgl_s), .pulse_o(ack_evt));

  rtt_toggle_sync #(.STAGES(2)) u_alarm_sync (
    .dst_clk(clk), .rst_n(rst_n), .tgl_in(alarm_tgl_s), .pulse_o(alarm_evt));

  rtt_bus_sync #(.W(CNT_W), .STAGES(2)) u_cnt_sync (
    .dst_clk(clk), .rst_n(rst_n), .din(cnt_slow), .dout(cnt_fast));

  rtt_slow_core #(.CNT_W(CNT_W), .DIV_W(DIV_W), .PRESC_RST(PRESC_RST)) u_core (
    .slow_clk(slow_clk), .rst_n(rst_n), .cfg_evt(cfg_evt_s),
    .presc_in(presc_r), .alarm_in(alarm_r), .clr_in(clr_r),
    .cnt_o(cnt_slow), .ack_tgl_o(ack_tgl_s), .alarm_tgl_o(alarm_tgl_s));

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && (int'(bus_addr) >= IX_END)) |=> (bus_rdata == '0));

  assert_clr_bit_reads0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && (int'(bus_addr) == IX_MODE)) |=> !bus_rdata[CLR_BIT]);

  assert_value_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_value && clr_r) |=> (bus_rdata == '0));

  assert_status_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !alarm_evt) |=> !irq);

  for (genvar g = 0; g < NBK; g++) begin : g_bk_chk
    assert_backup_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_any && (int'(bus_addr) == IX_BK0 + g)) |=> $stable(bkup[g]));
  end
endmodule

// File: tb/sim_rt_seconds_timer.sv
module sim_rt_seconds_timer;
  logic        clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0, wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  typedef struct {
    logic [31:0] lo;
    logic [31:0] hi;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0, fails = 0;
  logic rd_pend = 1'b0;

  always #4  clk = ~clk;       // 125 MHz
  always #28 slow_clk = ~slow_clk;

  rt_seconds_timer u0 (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_sel(sel), .bus_wr(wr_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

  localparam logic [31:0] CLR = 32'h0001_0000;  // clear bit 16

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic bread(input logic [3:0] a, input logic [31:0] lo, input logic [31:0] hi, input string tag);
    exp_t e;
    e.lo = lo; e.hi = hi; e.tag = tag;
    @(negedge clk); exp_q.push_back(e); sel = 1'b1; wr_en = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0;
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_pend <= sel && !wr_en;
  always @(negedge clk) begin
    if (rd_pend) begin
      exp_t e;
      e = exp_q.pop_front();
      chk((rdata >= e.lo) && (rdata <= e.hi), e.tag, rdata, e.lo);
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #1_000_000;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    idle(6);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);
    bread(4'd0, 32'h8000, 32'h8000, "R1 mode reset");
    bread(4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 alarm reset");
    bread(4'd3, 0, 0, "R1 status reset");
    for (int i = 4; i < 8; i++) bread(4'(i), 0, 0, "R1 backup reset");
    // R2 unmapped indices
    bwrite(4'd9, 32'hDEAD_BEEF);
    bread(4'd9, 0, 0, "R2 unmapped write ignored");
    bread(4'd15, 0, 0, "R2 unmapped reads zero");
    // R10 backup patterns
    for (int i = 0; i < 4; i++) bwrite(4'(4 + i), 32'hA5A5_A5A5 ^ (32'h1111_1111 * (i + 1)));
    for (int i = 0; i < 4; i++) bread(4'(4 + i), 32'hA5A5_A5A5 ^ (32'h1111_1111 * (i + 1)),
                                      32'hA5A5_A5A5 ^ (32'h1111_1111 * (i + 1)), "R10 backup readback");
    // R5/R6 clear with divider 4, then R3 count rate
    bwrite(4'd0, CLR | 32'd4);
    bread(4'd2, 0, 0, "R6 value masked after clear");
    bread(4'd0, 4, 4, "R5 field kept, clear bit reads 0");
    idle(280);
    bread(4'd2, 8, 10, "R3 divide by 4 over 40 slow cycles");
    for (int i = 0; i < 4; i++) bread(4'(4 + i), 32'hA5A5_A5A5 ^ (32'h1111_1111 * (i + 1)),
                                      32'hA5A5_A5A5 ^ (32'h1111_1111 * (i + 1)), "R10 backup after clear");
    // R7 value not writable
    bwrite(4'd0, CLR | 32'd1000);
    idle(40);
    bwrite(4'd2, 32'h0000_1234);
    bread(4'd2, 0, 0, "R7 value write ignored");
    // R4 divider 0 and 1
    bwrite(4'd0, CLR | 32'd0);
    idle(140);
    bread(4'd2, 15, 20, "R4 divider 0 steps every slow cycle");
    bwrite(4'd0, CLR | 32'd1);
    idle(140);
    bread(4'd2, 15, 20, "R4 divider 1 steps every slow cycle");
    // R8 alarm at 50
    bwrite(4'd1, 32'd50);
    idle(40);
    bwrite(4'd0, CLR | 32'd2);
    idle(100);
    chk(irq == 1'b0, "R8 no irq before match", 32'(irq), 0);
    bread(4'd3, 0, 0, "R8 status clear before match");
    for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
    chk(irq == 1'b1, "R8 irq at match", 32'(irq), 1);
    bread(4'd2, 50, 51, "R8 count at alarm");
    bread(4'd3, 1, 1, "R8 status set");
    chk(irq == 1'b0, "R8 irq cleared by status read", 32'(irq), 0);
    bread(4'd3, 0, 0, "R8 status cleared");
    // R9 all-ones alarm
    bwrite(4'd1, 32'hFFFF_FFFF);
    idle(40);
    bwrite(4'd0, CLR | 32'd0);
    idle(400);
    chk(irq == 1'b0, "R9 all-ones alarm silent", 32'(irq), 0);
    bread(4'd3, 0, 0, "R9 status stays clear");
    bread(4'd4, 32'hA5A5_A5A5 ^ 32'h1111_1111, 32'hA5A5_A5A5 ^ 32'h1111_1111, "R10 backup after many clears");
    idle(6);
    if (exp_q.size() != 0) chk(1'b0, "R2 read results missing", 32'(exp_q.size()), 0);
    summary();
  end
endmodule